// File: doc/BRIEF.md
# Fixed-Point Scale Step Generator

This block turns a source size and a destination size (a width or a height, in pixels) into the fixed-point resampling step that a video scaler advances by for each output pixel or line. The step has 21 fractional bits, so a one-to-one ratio gives 0x00200000. Before it divides, the block picks a coarse pre-divide of 1, 2 or 4 from the size ratio. It reports that choice as a 2-bit code so the scaler can reduce its output size to match. The source is shifted right by the pre-divide and then multiplied by 2^21. The result is divided by the destination, and the quotient is always rounded up.

The block also derives the values that the luma and chroma paths need. An axis select input chooses between the horizontal and the vertical rules. A one-cycle start pulse begins a calculation. The work is done by a sequential restoring divider that produces one quotient bit per cycle. All results are updated together and marked by a one-cycle done pulse. A zero destination is refused with a one-cycle error pulse.

Top module: `scaleStepGen`

## Requirements
- R1: After reset, every step output and `divCode` are zero, and `done`, `err` and `busy` are low.
- R2: When `dstSize >= srcSize`, the step is calculated with no pre-divide. `divCode` is 2'b00 and `masterStep` = ceil(srcSize * 2^21 / dstSize).
- R3: When `dstSize < srcSize` and `2*dstSize >= srcSize`, `divCode` is 2'b01. The dividend is (srcSize >> 1) * 2^21.
- R4: When `2*dstSize < srcSize`, `divCode` is 2'b10. The dividend is (srcSize >> 2) * 2^21.
- R5: The quotient is rounded up: one is added whenever the remainder is nonzero. An exact division is not changed.
- R6: A rounded quotient that does not fit in 32 bits is reported as 32'hFFFFFFFF.
- R7: With `axisVert` = 0, `lumaStep` and `chromaStep` are each `masterStep >> 2`, and `auxStep` is `masterStep >> 1`.
- R8: With `axisVert` = 1, `lumaStep` is `masterStep >> 2`. `chromaStep` is `masterStep >> 2` when `divCode` is 2'b00 and `masterStep >> 3` otherwise. `auxStep` is `lumaStep + 32'h514`.
- R9: A start with `dstSize` = 0 pulses `err` high for one cycle after the start edge. In that case there is no `done` and all step outputs and `divCode` keep their previous values.
- R10: `done` is a one-cycle pulse that rises on the 38th rising edge after the edge that samples `start`. `busy` is high from the edge after the start edge until `done` rises, and all outputs change only together with `done`.
- R11: A `start` seen while `busy` is high is ignored: it produces no result and does not alter the calculation in progress.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| start | input | 1 | One-cycle request to compute a step |
| axisVert | input | 1 | 0 = horizontal derivation rules, 1 = vertical |
| srcSize | input | 16 | Source size in pixels or lines |
| dstSize | input | 16 | Destination size in pixels or lines |
| masterStep | output | 32 | Rounded-up step, 21 fractional bits |
| lumaStep | output | 32 | Derived luma step |
| chromaStep | output | 32 | Derived chroma step |
| auxStep | output | 32 | Third derived value (half step or luma plus offset) |
| divCode | output | 2 | Pre-divide code: 00 none, 01 by 2, 10 by 4 |
| done | output | 1 | One-cycle pulse: outputs were updated |
| err | output | 1 | One-cycle pulse: start with zero destination refused |
| busy | output | 1 | Calculation in progress |

## Verification
A valid start produces its results and the `done` pulse 38 rising edges after the start edge. A refused start produces `err` one edge after it, and `busy` is visible one edge after an accepted start. When the driver issues a request, it records the due time in falling-edge units along with the expected values. The monitor compares each pulse on a falling edge against the oldest queued entry, including that due time. It flags any entry still pending once its due time has passed, and any pulse that arrives with nothing queued. This also catches a stray extra result caused by a start that the block should have ignored.

// File: rtl/scaleStepPkg.sv
package scaleStepPkg;

  typedef struct packed {
    logic load;
    logic step;
    logic finish;
  } ctrlStrobeT;

  typedef enum logic [1:0] {
    DIV_NONE    = 2'b00,
    DIV_HALF    = 2'b01,
    DIV_QUARTER = 2'b10
  } preDivE;

endpackage

// File: rtl/scaleStepCtrl.sv
module scaleStepCtrl
  import scaleStepPkg::*;
#(
  parameter int ITER = 37
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       start,
  input  logic       dstZero,
  output ctrlStrobeT strobes,
  output logic       done,
  output logic       err,
  output logic       busy
);
  localparam int CNT_W = $clog2(ITER);
  localparam logic [CNT_W-1:0] LAST_CNT = CNT_W'(ITER - 1);

  typedef enum logic [1:0] {ST_IDLE, ST_RUN, ST_FIN} stateE;

  stateE state;
  logic [CNT_W-1:0] iterCnt;

  always_comb begin
    strobes.load   = (state == ST_IDLE) && start && !dstZero;
    strobes.step   = (state == ST_RUN);
    strobes.finish = (state == ST_FIN);
  end

  assign busy = (state != ST_IDLE);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      iterCnt <= '0;
      done    <= 1'b0;
      err     <= 1'b0;
    end else begin
      done <= strobes.finish;
      err  <= (state == ST_IDLE) && start && dstZero;
      unique case (state)
        ST_IDLE: if (strobes.load) begin
          state   <= ST_RUN;
          iterCnt <= '0;
        end
        ST_RUN: begin
          iterCnt <= iterCnt + 1'b1;
          if (iterCnt == LAST_CNT) state <= ST_FIN;
        end
        ST_FIN:  state <= ST_IDLE;
        default: state <= ST_IDLE;
      endcase
    end
  end

  // R10
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  // R9
  err_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    err |-> !busy && !done);

  // R11
  strobe_excl_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strobes.load, strobes.step, strobes.finish}));

  // R11
  no_restart_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busy && start) |=> busy || done);

endmodule

// File: rtl/scaleStepData.sv
module scaleStepData
  import scaleStepPkg::*;
#(
  parameter int          SIZE_W   = 16,
  parameter int          FRAC_W   = 21,
  parameter int          STEP_W   = 32,
  parameter logic [31:0] VERT_ADD = 32'h514
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStrobeT        strobes,
  input  logic              axisVert,
  input  logic [SIZE_W-1:0] srcSize,
  input  logic [SIZE_W-1:0] dstSize,
  output logic [STEP_W-1:0] masterStep,
  output logic [STEP_W-1:0] lumaStep,
  output logic [STEP_W-1:0] chromaStep,
  output logic [STEP_W-1:0] auxStep,
  output logic [1:0]        divCode
);
  localparam int DIVD_W = SIZE_W + FRAC_W;

  // pre-divide choice
  preDivE            selCode;
  logic [SIZE_W-1:0] selSrc;

  always_comb begin
    if ({1'b0, dstSize} >= {1'b0, srcSize}) begin
      selCode = DIV_NONE;
      selSrc  = srcSize;
    end else if ({dstSize, 1'b0} >= {1'b0, srcSize}) begin
      selCode = DIV_HALF;
      selSrc  = srcSize >> 1;
    end else begin
      selCode = DIV_QUARTER;
      selSrc  = srcSize >> 2;
    end
  end

  // restoring divider state
  logic [DIVD_W-1:0] quo;
  logic [SIZE_W-1:0] rem;
  logic [SIZE_W-1:0] divisor;
  preDivE            codeR;
  logic              vertR;

  logic [SIZE_W:0] trial;
  logic            fits;
  assign trial = {rem, quo[DIVD_W-1]};
  assign fits  = (trial >= {1'b0, divisor});

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      quo     <= '0;
      rem     <= '0;
      divisor <= '0;
      codeR   <= DIV_NONE;
      vertR   <= 1'b0;
    end else if (strobes.load) begin
      quo     <= {selSrc, {FRAC_W{1'b0}}};
      rem     <= '0;
      divisor <= dstSize;
      codeR   <= selCode;
      vertR   <= axisVert;
    end else if (strobes.step) begin
      quo <= {quo[DIVD_W-2:0], fits};
      rem <= fits ? SIZE_W'(trial - {1'b0, divisor}) : trial[SIZE_W-1:0];
    end
  end

  // rounding, saturation and derived values
  logic [DIVD_W:0]   ceilQ;
  logic [STEP_W-1:0] satQ, nLuma, nChroma, nAux;

  always_comb begin
    ceilQ = {1'b0, quo} + {{DIVD_W{1'b0}}, (rem != '0)};
    satQ  = (|ceilQ[DIVD_W:STEP_W]) ? {STEP_W{1'b1}} : ceilQ[STEP_W-1:0];
    nLuma = satQ >> 2;
    if (vertR) begin
      nChroma = (codeR == DIV_NONE) ? (satQ >> 2) : (satQ >> 3);
      nAux    = nLuma + STEP_W'(VERT_ADD);
    end else begin
      nChroma = satQ >> 2;
      nAux    = satQ >> 1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      masterStep <= '0;
      lumaStep   <= '0;
      chromaStep <= '0;
      auxStep    <= '0;
      divCode    <= 2'b00;
    end else if (strobes.finish) begin
      masterStep <= satQ;
      lumaStep   <= nLuma;
      chromaStep <= nChroma;
      auxStep    <= nAux;
      divCode    <= codeR;
    end
  end

  // R9
  hold_result_chk: assert property (@(posedge clk) disable iff (!rstN)
    !strobes.finish |=> $stable(masterStep) && $stable(divCode));

  // R7
  luma_rel_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobes.finish |=> lumaStep == (masterStep >> 2));

  // R8
  vert_reduce_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.finish && vertR && codeR != DIV_NONE) |=> chromaStep == (masterStep >> 3));

  // R3
  code_legal_chk: assert property (@(posedge clk) disable iff (!rstN)
    divCode != 2'b11);

  // R5
  rem_bound_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobes.step |-> rem < divisor);

endmodule

// File: rtl/scaleStepGen.sv
module scaleStepGen
  import scaleStepPkg::*;
#(
  parameter int          SIZE_W   = 16,
  parameter int          FRAC_W   = 21,
  parameter int          STEP_W   = 32,
  parameter logic [31:0] VERT_ADD = 32'h514
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              start,
  input  logic              axisVert,
  input  logic [SIZE_W-1:0] srcSize,
  input  logic [SIZE_W-1:0] dstSize,
  output logic [STEP_W-1:0] masterStep,
  output logic [STEP_W-1:0] lumaStep,
  output logic [STEP_W-1:0] chromaStep,
  output logic [STEP_W-1:0] auxStep,
  output logic [1:0]        divCode,
  output logic              done,
  output logic              err,
  output logic              busy
);
  localparam int ITER = SIZE_W + FRAC_W;

  ctrlStrobeT strobes;

  scaleStepCtrl #(.ITER(ITER)) ctrl_i (
    .clk     (clk),
    .rstN    (rstN),
    .start   (start),
    .dstZero (dstSize == '0),
    .strobes (strobes),
    .done    (done),
    .err     (err),
    .busy    (busy)
  );

  scaleStepData #(
    .SIZE_W   (SIZE_W),
    .FRAC_W   (FRAC_W),
    .STEP_W   (STEP_W),
    .VERT_ADD (VERT_ADD)
  ) data_i (
    .clk        (clk),
    .rstN       (rstN),
    .strobes    (strobes),
    .axisVert   (axisVert),
    .srcSize    (srcSize),
    .dstSize    (dstSize),
    .masterStep (masterStep),
    .lumaStep   (lumaStep),
    .chromaStep (chromaStep),
    .auxStep    (auxStep),
    .divCode    (divCode)
  );

endmodule

// File: tb/scaleStepGen_tb_top.sv
module scaleStepGen_tb_top;
  localparam int LAT = 16 + 21 + 1;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic start = 1'b0;
  logic axisVert = 1'b0;
  logic [15:0] srcSize = '0, dstSize = '0;
  logic [31:0] masterStep, lumaStep, chromaStep, auxStep;
  logic [1:0] divCode;
  logic done, err, busy;

  always #10 clk = ~clk;

  scaleStepGen dut_i (
    .clk(clk), .rstN(rstN), .start(start), .axisVert(axisVert),
    .srcSize(srcSize), .dstSize(dstSize),
    .masterStep(masterStep), .lumaStep(lumaStep), .chromaStep(chromaStep),
    .auxStep(auxStep), .divCode(divCode), .done(done), .err(err), .busy(busy)
  );

  typedef struct {
    bit          isErr;
    int          due;
    logic [31:0] m, l, c, a;
    logic [1:0]  code;
    string       tag;
  } expT;

  expT expQ[$];
  expT lastGood;
  int  nChecks = 0;
  int  nFails = 0;
  int  negCnt = 0;

  task automatic check(input bit ok, input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  function automatic expT model(input bit vert, input int src, input int dst, input string tag);
    expT e;
    longint s, num, q;
    e.isErr = 0; e.tag = tag; e.due = 0;
    if (dst >= src) begin e.code = 2'b00; s = src; end
    else if (2 * dst >= src) begin e.code = 2'b01; s = src / 2; end
    else begin e.code = 2'b10; s = src / 4; end
    num = s * 64'd2097152;
    q = num / dst;
    if (num % dst != 0) q++;
    e.m = (q > 64'hFFFF_FFFF) ? 32'hFFFF_FFFF : q[31:0];
    e.l = e.m >> 2;
    if (vert) begin
      e.c = (e.code == 2'b00) ? (e.m >> 2) : (e.m >> 3);
      e.a = e.l + 32'h514;
    end else begin
      e.c = e.m >> 2;
      e.a = e.m >> 1;
    end
    return e;
  endfunction

  // driver: issue one request and queue what it must produce
  task automatic issue(input bit vert, input int src, input int dst, input string tag);
    expT e;
    @(negedge clk); #1;
    axisVert = vert; srcSize = 16'(src); dstSize = 16'(dst); start = 1'b1;
    if (dst == 0) begin
      e = lastGood; e.isErr = 1; e.due = negCnt + 1; e.tag = tag;
    end else begin
      e = model(vert, src, dst, tag); e.due = negCnt + 1 + LAT;
      lastGood = e;
    end
    expQ.push_back(e);
    @(negedge clk); #1;
    start = 1'b0;
    if (dst != 0) check(busy === 1'b1, "R10", "busy after start", 32'(busy), 32'd1);
    else check(busy === 1'b0, "R9", "busy after refused start", 32'(busy), 32'd0);
  endtask

  task automatic drain();
    while (expQ.size() != 0) @(negedge clk);
    repeat (2) @(negedge clk);
  endtask

  // monitor: compare each result pulse against the oldest queued item
  always @(negedge clk) begin
    negCnt++;
    if (done || err) begin
      if (expQ.size() == 0) begin
        check(0, "R11", "unexpected result pulse", {30'b0, done, err}, 32'd0);
      end else begin
        expT e;
        e = expQ.pop_front();
        check(e.isErr ? (err && !done) : (done && !err), e.tag, "pulse kind",
              {30'b0, done, err}, e.isErr ? 32'd1 : 32'd2);
        check(e.due == negCnt, "R10", "result timing", 32'(negCnt), 32'(e.due));
        check(masterStep === e.m, e.tag, "masterStep", masterStep, e.m);
        check(divCode === e.code, e.tag, "divCode", {30'b0, divCode}, {30'b0, e.code});
        check(lumaStep === e.l, e.tag, "lumaStep", lumaStep, e.l);
        check(chromaStep === e.c, e.tag, "chromaStep", chromaStep, e.c);
        check(auxStep === e.a, e.tag, "auxStep", auxStep, e.a);
      end
    end else if (expQ.size() != 0 && expQ[0].due < negCnt) begin
      check(0, expQ[0].tag, "result missing", 32'(negCnt), 32'(expQ[0].due));
      void'(expQ.pop_front());
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    nFails++;
    $display("FAIL watchdog expired");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

  initial begin
    lastGood = '{isErr: 0, due: 0, m: 0, l: 0, c: 0, a: 0, code: 0, tag: "R9"};
    repeat (3) @(negedge clk);
    // R1 reset state
    check(masterStep == 0 && lumaStep == 0 && chromaStep == 0 && auxStep == 0,
          "R1", "steps in reset", masterStep, 32'd0);
    check(divCode == 0 && !done && !err && !busy, "R1", "flags in reset",
          {26'b0, divCode, done, err, busy, 1'b0}, 32'd0);
    #1 rstN = 1'b1;
    repeat (2) @(negedge clk);

    issue(0, 360, 720, "R2");   drain();   // exact, enlarge, horizontal
    issue(0, 720, 720, "R2");   drain();   // unity ratio
    issue(1, 480, 576, "R5");   drain();   // enlarge with remainder, vertical
    issue(0, 720, 480, "R3");   drain();   // halve, horizontal
    issue(1, 720, 400, "R8");   drain();   // halve, vertical chroma >>3
    issue(1, 800, 400, "R3");   drain();   // exactly half boundary
    issue(1, 720, 200, "R4");   drain();   // quarter, vertical
    issue(0, 1000, 333, "R4");  drain();   // quarter, horizontal, rounding
    issue(0, 100, 7, "R7");     drain();   // horizontal derived values
    issue(1, 0, 100, "R8");     drain();   // zero source
    issue(0, 65535, 1, "R6");   drain();   // saturation
    issue(1, 640, 0, "R9");     drain();   // refused, outputs held
    issue(1, 333, 1000, "R5");  drain();

    // R11: a second start while busy must be ignored
    issue(0, 720, 480, "R11");
    repeat (5) @(negedge clk);
    #1;
    axisVert = 1'b1; srcSize = 16'd50; dstSize = 16'd3; start = 1'b1;
    @(negedge clk); #1 start = 1'b0;
    drain();
    repeat (LAT + 5) @(negedge clk);
    check(expQ.size() == 0, "R11", "queue empty", 32'(expQ.size()), 32'd0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

endmodule